// File: doc/BRIEF.md
# Address Sandbox and Bounds Unit

This unit sits on the address path between a processor and memory and confines every user-mode access to the region the operating system has granted. Each request carries a 24-bit virtual address, a write flag and a 3-bit function code. One cycle later the unit presents an effective address, a supervisor/user flag, a program/data flag and a fault flag. The region flags let a downstream decoder select between user and supervisor memory and between code and data.

Two confinement schemes can be selected. In sandbox mode the address is first masked, so that the segment field is cleared, and then ORed with a fixed segment identifier. In relocation mode a base register is added to the user offset, and the sum must lie inside the window from the lower limit up to the upper limit. Supervisor and interrupt-acknowledge cycles pass straight through. The configuration registers (mask, segment identifier, base, upper limit, lower limit and mode) sit behind a small control window. Only a supervisor data write can change them.

A two-state machine drives the response strobe. ST_IDLE moves to ST_RESP when a request is presented. ST_RESP stays in ST_RESP when a request follows at once and returns to ST_IDLE otherwise. ST_IDLE also stays in ST_IDLE while no request arrives.

Top module: `addr_guard`

## Requirements
- R1: After reset, out_valid and out_fault are 0 and out_addr is 0. The reset configuration selects sandbox mode with mask 0x00FFFF and segment identifier 0, so a user address keeps its low 16 bits and has its upper 8 bits cleared.
- R2: out_valid is 1 exactly in the cycle after a cycle with req_valid = 1. In that cycle out_addr, out_super, out_prog and out_fault describe that request. out_fault is never 1 while out_valid is 0.
- R3: In sandbox mode (mode bit 0 = 0), an accepted user access (function code 001 or 010) gives out_addr = (req_addr AND mask) OR segment identifier.
- R4: In relocation mode (mode bit 0 = 1), an accepted user access gives out_addr = base + req_addr.
- R5: In relocation mode, a user access whose sum is above the upper-limit register faults. A sum equal to the upper limit is accepted.
- R6: In relocation mode, a user access whose sum is below the lower-limit register faults, and so does a sum that carries out of 24 bits. A sum equal to the lower limit is accepted.
- R7: Supervisor codes 101 (data) and 110 (program) pass req_addr unchanged with no fault, in either mode.
- R8: Reserved codes 000, 011 and 100 always fault.
- R9: Interrupt-acknowledge code 111 passes req_addr unchanged with no fault.
- R10: A write with the user-program code 010 faults.
- R11: The control window is the set of addresses whose bits [23:4] are 0xFFFFF. Bits [2:0] select the register: 0 mask, 1 segment identifier, 2 base, 3 upper limit, 4 lower limit, 5 mode (bit 0 of the data). A configuration register is written only by a code-101 write inside the window, and the write uses req_wdata. A user-code write to a window address faults and changes nothing. Supervisor-program writes and code-101 reads to the window change nothing.
- R12: out_super is 1 only for codes 101, 110 and 111. out_prog is 1 only for codes 010 and 110.
- R13: Whenever out_fault is 1, out_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 24 | Virtual address or user offset |
| req_write | input | 1 | 1 for a write |
| req_fc | input | 3 | Processor function code |
| req_wdata | input | 24 | Write data, used for configuration writes |
| out_valid | output | 1 | Response strobe, one cycle after req_valid |
| out_addr | output | 24 | Effective address, 0 on a fault |
| out_super | output | 1 | Supervisor region select |
| out_prog | output | 1 | Program region select |
| out_fault | output | 1 | Protection fault |

## Verification
The assertions assume one request per cycle and inputs that are stable across the sampling edge. They also assume that configuration changes arrive only through code-101 writes to the control window. The bench drives each request on the falling edge and holds it for one full cycle. It changes configuration only through that path, so its shadow copy of the registers matches the design. The sweeps skip supervisor-data writes to the control window and exercise those writes only in directed steps. Every function code and write flag is swept against boundary addresses under four configurations: sandbox defaults, a narrower sandbox, a relocation window, and a base that forces a carry.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;

    typedef enum logic [2:0] {
        FC_RSV0     = 3'b000,
        FC_USR_DATA = 3'b001,
        FC_USR_PROG = 3'b010,
        FC_RSV3     = 3'b011,
        FC_RSV4     = 3'b100,
        FC_SUP_DATA = 3'b101,
        FC_SUP_PROG = 3'b110,
        FC_IACK     = 3'b111
    } fcode_e;

    typedef enum logic {
        MODE_SANDBOX = 1'b0,
        MODE_RELOC   = 1'b1
    } conf_mode_e;

    typedef enum logic [2:0] {
        SEL_MASK   = 3'd0,
        SEL_SEGID  = 3'd1,
        SEL_BASE   = 3'd2,
        SEL_UPPER  = 3'd3,
        SEL_LOWER  = 3'd4,
        SEL_MODE   = 3'd5
    } cfg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_e;

endpackage

// File: rtl/addr_guard_cfg.sv
module addr_guard_cfg
    import addr_guard_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] segid,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] upper,
    output logic [ADDR_W-1:0] lower,
    output logic              mode
);
    localparam int OFF_W = ADDR_W - SEG_W;
    localparam logic [ADDR_W-1:0] MASK_RST = {{SEG_W{1'b0}}, {OFF_W{1'b1}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask  <= MASK_RST;
            segid <= '0;
            base  <= '0;
            upper <= '1;
            lower <= '0;
            mode  <= MODE_SANDBOX;
        end else if (wr_en) begin
            case (cfg_sel_e'(wr_sel))
                SEL_MASK:  mask  <= wr_data;
                SEL_SEGID: segid <= wr_data;
                SEL_BASE:  base  <= wr_data;
                SEL_UPPER: upper <= wr_data;
                SEL_LOWER: lower <= wr_data;
                SEL_MODE:  mode  <= wr_data[0];
                default:   ;
            endcase
        end
    end

    // Configuration changes only on an enabled write (R11)
    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(mask) && $stable(segid) && $stable(base)
                    && $stable(upper) && $stable(lower) && $stable(mode)));

endmodule

// File: rtl/addr_guard_xlate.sv
module addr_guard_xlate
    import addr_guard_pkg::*;
#(
    parameter int              ADDR_W    = 24,
    parameter int              WIN_LSB   = 4,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 24'hFFFFF0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic [2:0]        fc,
    input  logic [ADDR_W-1:0] mask,
    input  logic [ADDR_W-1:0] segid,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] upper,
    input  logic [ADDR_W-1:0] lower,
    input  logic              mode,
    output logic [ADDR_W-1:0] eff,
    output logic              fault,
    output logic              is_super,
    output logic              is_prog,
    output logic              cfg_we
);
    logic              in_win;
    logic [ADDR_W:0]   sum;
    logic              out_of_window;

    assign in_win = (addr[ADDR_W-1:WIN_LSB] == CTRL_BASE[ADDR_W-1:WIN_LSB]);
    assign sum    = {1'b0, base} + {1'b0, addr};
    assign out_of_window = sum[ADDR_W]
                         || (sum[ADDR_W-1:0] > upper)
                         || (sum[ADDR_W-1:0] < lower);

    always_comb begin
        eff      = '0;
        fault    = 1'b0;
        is_super = 1'b0;
        is_prog  = 1'b0;
        cfg_we   = 1'b0;
        unique case (fcode_e'(fc))
            FC_USR_DATA, FC_USR_PROG: begin
                is_prog = (fcode_e'(fc) == FC_USR_PROG);
                if (write && (is_prog || in_win)) begin
                    fault = 1'b1;
                end else if (mode == MODE_SANDBOX) begin
                    eff = (addr & mask) | segid;
                end else if (out_of_window) begin
                    fault = 1'b1;
                end else begin
                    eff = sum[ADDR_W-1:0];
                end
            end
            FC_SUP_DATA: begin
                is_super = 1'b1;
                eff      = addr;
                cfg_we   = write && in_win;
            end
            FC_SUP_PROG: begin
                is_super = 1'b1;
                is_prog  = 1'b1;
                eff      = addr;
            end
            FC_IACK: begin
                is_super = 1'b1;
                eff      = addr;
            end
            FC_RSV0, FC_RSV3, FC_RSV4: begin
                fault = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/addr_guard.sv
module addr_guard
    import addr_guard_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter int                SEG_W     = 8,
    parameter int                WIN_LSB   = 4,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 24'hFFFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [2:0]        req_fc,
    input  logic [ADDR_W-1:0] req_wdata,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_super,
    output logic              out_prog,
    output logic              out_fault
);
    resp_state_e state_q, state_nx;

    logic [ADDR_W-1:0] c_mask, c_segid, c_base, c_upper, c_lower;
    logic              c_mode;
    logic [ADDR_W-1:0] x_eff;
    logic              x_fault, x_super, x_prog, x_cfg_we;

    addr_guard_cfg #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (req_valid && x_cfg_we),
        .wr_sel  (req_addr[2:0]),
        .wr_data (req_wdata),
        .mask    (c_mask),
        .segid   (c_segid),
        .base    (c_base),
        .upper   (c_upper),
        .lower   (c_lower),
        .mode    (c_mode)
    );

    addr_guard_xlate #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .CTRL_BASE(CTRL_BASE)) u_xlate (
        .addr     (req_addr),
        .write    (req_write),
        .fc       (req_fc),
        .mask     (c_mask),
        .segid    (c_segid),
        .base     (c_base),
        .upper    (c_upper),
        .lower    (c_lower),
        .mode     (c_mode),
        .eff      (x_eff),
        .fault    (x_fault),
        .is_super (x_super),
        .is_prog  (x_prog),
        .cfg_we   (x_cfg_we)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_nx = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    // Output strobe decoded from state
    always_comb begin
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: out_valid = 1'b0;
            ST_RESP: out_valid = 1'b1;
        endcase
    end

    // Registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr  <= '0;
            out_super <= 1'b0;
            out_prog  <= 1'b0;
            out_fault <= 1'b0;
        end else begin
            out_fault <= req_valid && x_fault;
            if (req_valid) begin
                out_addr  <= x_eff;
                out_super <= x_super;
                out_prog  <= x_prog;
            end
        end
    end

    assert_valid_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    assert_idle_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    assert_fault_in_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> out_valid);
    assert_reserved_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_fc == 3'b000 || req_fc == 3'b011 || req_fc == 3'b100)) |=> out_fault);
    assert_uprog_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fc == 3'b010 && req_write) |=> out_fault);
    assert_super_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_fc == 3'b101 || req_fc == 3'b110))
        |=> (!out_fault && out_addr == $past(req_addr) && out_super));
    assert_iack_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fc == 3'b111) |=> (!out_fault && out_addr == $past(req_addr)));
    assert_fault_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (out_addr == '0));

endmodule

// File: tb/addr_guard_bench.sv
module addr_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic [2:0]    req_fc = 3'b000;
    logic [AW-1:0] req_wdata = '0;
    logic          out_valid;
    logic [AW-1:0] out_addr;
    logic          out_super;
    logic          out_prog;
    logic          out_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [AW-1:0] m_mask  = 24'h00FFFF;
    logic [AW-1:0] m_seg   = 24'h000000;
    logic [AW-1:0] m_base  = 24'h000000;
    logic [AW-1:0] m_upper = 24'hFFFFFF;
    logic [AW-1:0] m_lower = 24'h000000;
    logic          m_mode  = 1'b0;

    logic [AW-1:0] addrs [12] = '{24'h000000, 24'h00000F, 24'h000010, 24'h123456,
                                  24'h2FFFFF, 24'h300000, 24'h7FFFFF, 24'h800000,
                                  24'hABCDEF, 24'hFFFFF2, 24'hFFFFF5, 24'hFFFFFF};

    addr_guard u_addr_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_fc    (req_fc),
        .req_wdata (req_wdata),
        .out_valid (out_valid),
        .out_addr  (out_addr),
        .out_super (out_super),
        .out_prog  (out_prog),
        .out_fault (out_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [AW-1:0] a, input logic w, input logic [2:0] f,
                          input logic [AW-1:0] d);
        @(negedge clk);
        req_addr = a; req_write = w; req_fc = f; req_wdata = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic cfg_set(input int idx, input logic [AW-1:0] d);
        do_req(24'hFFFFF0 | AW'(idx), 1'b1, 3'b101, d);
        case (idx)
            0: m_mask  = d;
            1: m_seg   = d;
            2: m_base  = d;
            3: m_upper = d;
            4: m_lower = d;
            5: m_mode  = d[0];
            default: ;
        endcase
    endtask

    function automatic logic in_win(input logic [AW-1:0] a);
        return a[23:4] == 20'hFFFFF;
    endfunction

    // Returns {fault, super, prog, addr}
    function automatic logic [26:0] model(input logic [AW-1:0] a, input logic w,
                                          input logic [2:0] f);
        logic flt, sup, prg;
        logic [AW-1:0] e;
        logic [AW:0] s;
        flt = 1'b0; e = '0;
        sup = (f == 3'd5 || f == 3'd6 || f == 3'd7);
        prg = (f == 3'd2 || f == 3'd6);
        s = {1'b0, m_base} + {1'b0, a};
        case (f)
            3'd1, 3'd2: begin
                if (w && (f == 3'd2 || in_win(a))) flt = 1'b1;
                else if (!m_mode) e = (a & m_mask) | m_seg;
                else if (s[AW] || s[AW-1:0] > m_upper || s[AW-1:0] < m_lower) flt = 1'b1;
                else e = s[AW-1:0];
            end
            3'd5, 3'd6, 3'd7: e = a;
            default: flt = 1'b1;
        endcase
        if (flt) e = '0;
        return {flt, sup, prg, e};
    endfunction

    function automatic string tag_of(input logic [AW-1:0] a, input logic w, input logic [2:0] f);
        logic [AW:0] s;
        s = {1'b0, m_base} + {1'b0, a};
        if (f == 3'd0 || f == 3'd3 || f == 3'd4) return "R8 reserved code";
        if (f == 3'd7) return "R9 interrupt acknowledge";
        if (f == 3'd5 || f == 3'd6) return "R7 supervisor pass";
        if (f == 3'd2 && w) return "R10 user program write";
        if (w && in_win(a)) return "R11 user control write";
        if (!m_mode) return "R3 sandbox";
        if (s[AW] || s[AW-1:0] < m_lower) return "R6 lower limit or carry";
        if (s[AW-1:0] > m_upper) return "R5 upper limit";
        return "R4 relocation";
    endfunction

    task automatic sweep();
        logic [26:0] exp;
        for (int i = 0; i < 12; i++) begin
            for (int f = 0; f < 8; f++) begin
                for (int w = 0; w < 2; w++) begin
                    if (!(f == 5 && w == 1 && in_win(addrs[i]))) begin
                        do_req(addrs[i], w[0], f[2:0], 24'h0);
                        exp = model(addrs[i], w[0], f[2:0]);
                        check(tag_of(addrs[i], w[0], f[2:0]),
                              {7'd0, out_fault, out_addr}, {7'd0, exp[26], exp[23:0]});
                        check("R12 region select", {30'd0, out_super, out_prog},
                              {30'd0, exp[25:24]});
                        check("R2 response strobe", {31'd0, out_valid}, 32'd1);
                        if (exp[26]) check("R13 faulted address zero", {8'd0, out_addr}, 32'd0);
                    end
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog expired actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset fault", {31'd0, out_fault}, 32'd0);
        check("R1 reset addr", {8'd0, out_addr}, 32'd0);

        do_req(24'hAB1234, 1'b0, 3'b001, 24'h0);
        check("R1 reset config sandbox", {8'd0, out_addr}, 32'h001234);
        @(negedge clk);
        check("R2 strobe drops", {31'd0, out_valid}, 32'd0);

        sweep();

        cfg_set(0, 24'h003FFF);
        cfg_set(1, 24'h5A0000);
        sweep();

        cfg_set(2, 24'h100000);
        cfg_set(3, 24'h3FFFFF);
        cfg_set(4, 24'h100010);
        cfg_set(5, 24'h000001);
        sweep();

        // R11 directed: writes that must not touch the configuration
        do_req(24'hFFFFF2, 1'b1, 3'b001, 24'h000055);
        check("R11 user write to control faults", {31'd0, out_fault}, 32'd1);
        do_req(24'hFFFFF2, 1'b1, 3'b110, 24'h000055);
        check("R11 supervisor program write passes", {31'd0, out_fault}, 32'd0);
        do_req(24'hFFFFF2, 1'b0, 3'b101, 24'h000055);
        check("R11 supervisor read passes", {31'd0, out_fault}, 32'd0);
        do_req(24'h000100, 1'b0, 3'b001, 24'h0);
        check("R11 base unchanged", {7'd0, out_fault, out_addr}, {7'd0, 1'b0, 24'h100100});

        cfg_set(2, 24'hF00000);
        cfg_set(3, 24'hFFFFFF);
        cfg_set(4, 24'h000000);
        sweep();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule